// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Hazard Control

This block is the control side of a five-stage in-order pipeline. Each cycle it compares the source registers of the instruction in the execute stage against the destinations of the two instructions ahead of it. It then drives the select codes of the two ALU operand multiplexers, so that a result not yet written back reaches the ALU in time. The second operand multiplexer sits ahead of the register-or-immediate choice, so a forwarded value always feeds the register side of that choice.

A third select controls a path from the write-back stage into the store data of the memory stage. A store that writes out a register loaded by the instruction just before it therefore receives the loaded value, not the register's stale contents, and costs no stall. Every other consumer of a load in the following instruction still cannot be covered. For those, the block asks for a one-cycle stall: the program counter and the fetch/decode register hold, and a bubble enters the decode/execute register.

The block is purely combinational and has no state. Register width is a parameter, and register 0 is treated as a constant zero that is never a forwarding source.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each ALU operand select (`fwd_a` for the first source, `fwd_b` for the second) is 2'b00 when neither later stage supplies that source.
- R2: An operand select is 2'b10 when the memory-stage instruction writes a register (`mem_regwrite`=1) whose number equals that source.
- R3: An operand select is 2'b01 when only the write-back-stage instruction (`wb_regwrite`=1) writes a register equal to that source.
- R4: When both later stages write the source register, the memory stage wins and the select is 2'b10.
- R5: A source of register 0 never produces a nonzero operand select.
- R6: A stage whose register-write flag is 0 never causes forwarding, whatever its destination number.
- R7: `fwd_store` is 1 exactly when the memory-stage instruction is a store, the write-back instruction is a load with its write flag set, and the load's nonzero destination equals the store's data register. In every other case it is 0.
- R8: A load in the execute stage with a nonzero destination equal to the decode-stage first source (flag `id_rs_used`=1) causes a stall.
- R9: A load in the execute stage whose nonzero destination equals the decode-stage second source (flag `id_rt_used`=1) causes a stall when the decode instruction is not a store.
- R10: A decode-stage store that uses the loaded register only as its data register causes no stall. If it also uses that register as its address base, it stalls.
- R11: `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 during a stall and all 0 otherwise.
- R12: No stall arises when the execute-stage instruction is not a load, when its destination is register 0, or when the matching decode source is flagged unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | ADDR_W | First source register of the instruction in decode |
| id_rt | input | ADDR_W | Second source register of the instruction in decode |
| id_rs_used | input | 1 | Decode instruction reads its first source |
| id_rt_used | input | 1 | Decode instruction reads its second source |
| id_store | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs | input | ADDR_W | First source register held in the decode/execute register |
| ex_rt | input | ADDR_W | Second source register held in the decode/execute register |
| ex_rd | input | ADDR_W | Destination register of the execute-stage instruction |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | ADDR_W | Destination register in the execute/memory register |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_rt | input | ADDR_W | Store data register of the memory-stage instruction |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | ADDR_W | Destination register in the memory/write-back register |
| wb_regwrite | input | 1 | Write-back-stage instruction writes a register |
| wb_load | input | 1 | Write-back-stage instruction is a load |
| fwd_a | output | 2 | First ALU operand select: 00 pipeline value, 01 from write-back, 10 from memory stage |
| fwd_b | output | 2 | Second ALU operand select, same coding, applied before the immediate choice |
| fwd_store | output | 1 | Store data in memory stage taken from the write-back result |
| pc_hold | output | 1 | Hold the program counter this cycle |
| ifid_hold | output | 1 | Hold the fetch/decode register this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench builds the unit with a 3-bit register number, so only eight registers exist. That makes it practical to sweep every source against every memory and write-back destination under all write-flag settings. The same size allows every load destination to be crossed with both decode sources, the store flag and both use flags. The register-0 exclusion, the memory-over-write-back priority and the store-data exemption from the stall are therefore all covered by full enumeration rather than by chosen examples.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_NONE     = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_e;

    // Nearer producer wins: memory stage holds the younger result.
    function automatic fwd_sel_e fwd_pick(input logic hit_mem, input logic hit_wb);
        if (hit_mem)
            return FWD_FROM_MEM;
        else if (hit_wb)
            return FWD_FROM_WB;
        else
            return FWD_NONE;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic              dst_valid,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = dst_valid && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/alu_fwd_sel.sv
module alu_fwd_sel
    import fwd_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [NUM_OPS-1:0][ADDR_W-1:0] srcs,
    input  logic [ADDR_W-1:0]              mem_rd,
    input  logic                           mem_wr,
    input  logic [ADDR_W-1:0]              wb_rd,
    input  logic                           wb_wr,
    output logic [NUM_OPS-1:0][SEL_W-1:0]  sels
);
    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        logic     hit_mem;
        logic     hit_wb;
        fwd_sel_e sel;

        fwd_match #(.ADDR_W(ADDR_W)) u_mem (
            .src(srcs[op]), .dst(mem_rd), .dst_valid(mem_wr), .hit(hit_mem)
        );
        fwd_match #(.ADDR_W(ADDR_W)) u_wb (
            .src(srcs[op]), .dst(wb_rd), .dst_valid(wb_wr), .hit(hit_wb)
        );

        always_comb begin
            sel      = fwd_pick(hit_mem, hit_wb);
            sels[op] = sel;
        end

        always_comb begin
            if (hit_mem)
                assert_mem_priority_R4: assert (sels[op] == FWD_FROM_MEM)
                    else $error("memory-stage match not selected");
            if (srcs[op] == ZERO_REG)
                assert_zero_reg_R5: assert (sels[op] == FWD_NONE)
                    else $error("register 0 forwarded");
            if (!mem_wr && !wb_wr)
                assert_no_writer_R6: assert (sels[op] == FWD_NONE)
                    else $error("forwarding without a writer");
        end
    end
endmodule

// File: rtl/store_fwd_sel.sv
module store_fwd_sel #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] mem_rt,
    input  logic              mem_store,
    input  logic [ADDR_W-1:0] wb_rd,
    input  logic              wb_regwrite,
    input  logic              wb_load,
    output logic              fwd_store
);
    logic hit;

    fwd_match #(.ADDR_W(ADDR_W)) u_hit (
        .src(mem_rt), .dst(wb_rd), .dst_valid(wb_regwrite && wb_load), .hit(hit)
    );

    always_comb begin
        fwd_store = mem_store && hit;
    end

    always_comb begin
        if (fwd_store)
            assert_store_src_R7: assert (wb_load && mem_store && (wb_rd == mem_rt))
                else $error("store data forwarded from non-load");
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] id_rs,
    input  logic [ADDR_W-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic              id_store,
    input  logic [ADDR_W-1:0] ex_rd,
    input  logic              ex_load,
    output logic              stall
);
    logic hit_rs;
    logic hit_rt;

    fwd_match #(.ADDR_W(ADDR_W)) u_rs (
        .src(id_rs), .dst(ex_rd), .dst_valid(ex_load), .hit(hit_rs)
    );
    fwd_match #(.ADDR_W(ADDR_W)) u_rt (
        .src(id_rt), .dst(ex_rd), .dst_valid(ex_load), .hit(hit_rt)
    );

    // Store data is covered later by the write-back to memory-stage path.
    always_comb begin
        stall = (id_rs_used && hit_rs) || (id_rt_used && hit_rt && !id_store);
    end

    always_comb begin
        if (stall)
            assert_stall_needs_load_R12: assert (ex_load)
                else $error("stall without load in execute");
        if (id_store && !(id_rs_used && hit_rs))
            assert_store_data_free_R10: assert (!stall)
                else $error("store data dependency stalled");
    end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] id_rs,
    input  logic [ADDR_W-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic              id_store,
    input  logic [ADDR_W-1:0] ex_rs,
    input  logic [ADDR_W-1:0] ex_rt,
    input  logic [ADDR_W-1:0] ex_rd,
    input  logic              ex_load,
    input  logic [ADDR_W-1:0] mem_rd,
    input  logic              mem_regwrite,
    input  logic [ADDR_W-1:0] mem_rt,
    input  logic              mem_store,
    input  logic [ADDR_W-1:0] wb_rd,
    input  logic              wb_regwrite,
    input  logic              wb_load,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              fwd_store,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    localparam int NUM_OPS = 2;
    localparam int OP_A    = 0;
    localparam int OP_B    = 1;

    logic [NUM_OPS-1:0][ADDR_W-1:0] ex_srcs;
    logic [NUM_OPS-1:0][SEL_W-1:0]  op_sels;
    logic                           stall;

    always_comb begin
        ex_srcs[OP_A] = ex_rs;
        ex_srcs[OP_B] = ex_rt;
    end

    alu_fwd_sel #(.ADDR_W(ADDR_W), .NUM_OPS(NUM_OPS)) u_alu (
        .srcs(ex_srcs), .mem_rd(mem_rd), .mem_wr(mem_regwrite),
        .wb_rd(wb_rd), .wb_wr(wb_regwrite), .sels(op_sels)
    );

    store_fwd_sel #(.ADDR_W(ADDR_W)) u_store (
        .mem_rt(mem_rt), .mem_store(mem_store), .wb_rd(wb_rd),
        .wb_regwrite(wb_regwrite), .wb_load(wb_load), .fwd_store(fwd_store)
    );

    load_use_detect #(.ADDR_W(ADDR_W)) u_luse (
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used),
        .id_rt_used(id_rt_used), .id_store(id_store),
        .ex_rd(ex_rd), .ex_load(ex_load), .stall(stall)
    );

    always_comb begin
        fwd_a       = op_sels[OP_A];
        fwd_b       = op_sels[OP_B];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end

    always_comb begin
        if (id_rs_used && ex_load && (ex_rd == id_rs) && (id_rs != '0))
            assert_rs_stall_R8: assert (idex_bubble && pc_hold)
                else $error("load-use on first source not stalled");
        if (!ex_load)
            assert_no_load_R12: assert (!pc_hold && !ifid_hold && !idex_bubble)
                else $error("hold without load");
    end
endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 3;
    localparam int NREG       = 1 << AW;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd;
    logic id_rs_used, id_rt_used, id_store, ex_load;
    logic mem_regwrite, mem_store, wb_regwrite, wb_load;
    logic [1:0] fwd_a, fwd_b;
    logic fwd_store, pc_hold, ifid_hold, idex_bubble;

    fwd_hazard_unit #(.ADDR_W(AW)) uut (
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .id_store(id_store), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_rt(mem_rt), .mem_store(mem_store),
        .wb_rd(wb_rd), .wb_regwrite(wb_regwrite), .wb_load(wb_load),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_store(fwd_store),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic done   = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd} = '0;
        {id_rs_used, id_rt_used, id_store, ex_load} = '0;
        {mem_regwrite, mem_store, wb_regwrite, wb_load} = '0;
    endtask

    function automatic int exp_sel(int src, int mrd, int mw, int wrd, int ww);
        if (mw != 0 && mrd != 0 && mrd == src) return 2;
        if (ww != 0 && wrd != 0 && wrd == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src, int mrd, int mw, int wrd, int ww);
        bit m = (mrd == src);
        bit w = (wrd == src);
        if (src == 0 && (m || w)) return "R5";
        if ((m && mw == 0) || (w && ww == 0)) return "R6";
        if (m && w) return "R4";
        if (m) return "R2";
        if (w) return "R3";
        return "R1";
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        // R1 / R11: idle pipeline gives pass-through selects and no hold
        check("R1 idle fwd_a", fwd_a, 0);
        check("R1 idle fwd_b", fwd_b, 0);
        check("R7 idle fwd_store", fwd_store, 0);
        check("R11 idle hold", {pc_hold, ifid_hold, idex_bubble}, 0);

        // Operand select sweep: R1..R6
        for (int s = 0; s < NREG; s++)
            for (int mrd = 0; mrd < NREG; mrd++)
                for (int wrd = 0; wrd < NREG; wrd++)
                    for (int mw = 0; mw < 2; mw++)
                        for (int ww = 0; ww < 2; ww++) begin
                            int t = (s + 5) % NREG;
                            ex_rs = AW'(s); ex_rt = AW'(t);
                            mem_rd = AW'(mrd); wb_rd = AW'(wrd);
                            mem_regwrite = 1'(mw); wb_regwrite = 1'(ww);
                            #(CLK_PERIOD/2);
                            check({sel_tag(s, mrd, mw, wrd, ww), " fwd_a"}, fwd_a, exp_sel(s, mrd, mw, wrd, ww));
                            check({sel_tag(t, mrd, mw, wrd, ww), " fwd_b"}, fwd_b, exp_sel(t, mrd, mw, wrd, ww));
                        end
        idle_inputs();

        // Store-data select sweep: R7
        for (int srt = 0; srt < NREG; srt++)
            for (int wrd = 0; wrd < NREG; wrd++)
                for (int fl = 0; fl < 8; fl++) begin
                    int e;
                    mem_rt = AW'(srt); wb_rd = AW'(wrd);
                    mem_store = fl[0]; wb_load = fl[1]; wb_regwrite = fl[2];
                    e = (fl == 7 && wrd != 0 && wrd == srt) ? 1 : 0;
                    #(CLK_PERIOD/2);
                    check("R7 fwd_store", fwd_store, e);
                end
        idle_inputs();

        // Load-use stall sweep: R8..R12
        for (int d = 0; d < NREG; d++)
            for (int a = 0; a < NREG; a++)
                for (int b = 0; b < NREG; b++)
                    for (int fl = 0; fl < 16; fl++) begin
                        bit hs, ht, e;
                        string tag;
                        ex_rd = AW'(d); id_rs = AW'(a); id_rt = AW'(b);
                        ex_load = fl[0]; id_store = fl[1];
                        id_rs_used = fl[2]; id_rt_used = fl[3];
                        hs = fl[0] && d != 0 && d == a && fl[2];
                        ht = fl[0] && d != 0 && d == b && fl[3];
                        e  = hs || (ht && !fl[1]);
                        if (hs) tag = "R8";
                        else if (ht && fl[1]) tag = "R10";
                        else if (ht) tag = "R9";
                        else tag = "R12";
                        #(CLK_PERIOD/2);
                        check({tag, " pc_hold"}, pc_hold, int'(e));
                        check("R11 ifid_hold", ifid_hold, int'(e));
                        check("R11 idex_bubble", idex_bubble, int'(e));
                    end
        idle_inputs();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule